// File: doc/BRIEF.md
# Address-Dependent Wait-State Divider

This block decides how long each bus cycle of a small 8-bit audio co-processor lasts. An internal prescaler divides the master clock by 12 to make a base clock. Every cycle the core requests (idle, read or write) then takes a whole number of these base clocks, and the core holds its next request until the block raises a one-clock done strobe.

The number of base clocks comes from one of two 2-bit divider settings in a control register. The address picks which one: the internal setting for idle cycles, the I/O page and the boot ROM window, and the external setting for everything else. The two slow settings do not divide 12 evenly. For them the block charges the core a stretched, irregular cycle length on purpose. With the done strobe it also reports the regular number of base clocks that the timer prescalers should advance.

The same control register also holds the timer enable, RAM writable and RAM disable bits, which the block passes out as plain outputs.

Top module: `bus_wait_divider`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `timer_ticks_o` are 0. `timer_en_o` and `ram_writable_o` are 1 and `ram_disable_o` is 0. Both divider settings are 0, so any cycle lasts 2 base clocks.
- R2: A request is accepted on the rising clock edge where `req_valid_i` is 1 and `busy_o` is 0. One base clock equals 12 master clocks, and the base-clock phase restarts at acceptance. `done_o` is first seen high exactly L×12 master clock edges after the accepting edge, where L is the cycle length in base clocks.
- R3: The cycle length L for divider setting 0, 1, 2 and 3 is 2, 4, 10 and 20 base clocks.
- R4: While `done_o` is high, `timer_ticks_o` holds 2, 4, 8 or 16 for setting 0, 1, 2 or 3 of the cycle that finished. At all other times it is 0.
- R5: The request kind encoding is 0 = idle, 1 = read, 2 = write, 3 = treated as an access. The internal setting is control bits 7:6 and the external setting is control bits 5:4. The internal setting is used for idle cycles, for addresses 0x00F0 to 0x00FF, and for addresses at 0xFFC0 or above while `boot_rom_en_i` is 1. All other accesses use the external setting.
- R6: `done_o` is high for exactly one master clock, and `busy_o` is already 0 in that clock.
- R7: A request presented while `busy_o` is 1 is neither queued nor allowed to change the cycle in progress.
- R8: A control write takes effect at the next accepted request. A write during a cycle leaves that cycle's length and tick count unchanged.
- R9: On a control write, `timer_en_o` follows bit 3, `ram_disable_o` follows bit 2 and `ram_writable_o` follows bit 1. Bit 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Cycle request |
| req_kind_i | input | 2 | 0 idle, 1 read, 2 write |
| addr_i | input | 16 | Bus address of the cycle |
| boot_rom_en_i | input | 1 | Boot ROM window mapped |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock cycle-complete strobe |
| timer_ticks_o | output | 5 | Base clocks to advance the timers, valid with done |
| timer_en_o | output | 1 | Timer enable bit |
| ram_writable_o | output | 1 | RAM writable bit |
| ram_disable_o | output | 1 | RAM disable bit |

## Verification
The bench targets the address class boundaries: 0x00EF against 0x00F0, 0x00FF against 0x0100, and 0xFFBF against 0xFFC0 with the boot ROM window both on and off. A faulty decoder would time these addresses with the wrong divider field. It runs the two slow settings and checks that the core is charged 10 and 20 base clocks while the timers get 8 and 16. A model that charged both sides the same, or used the regular value for the core, fails those checks. It also writes the control register and issues a second request in the middle of a cycle. A design that reloaded its counter, queued the extra request, or let the new divider act at once would show a wrong length or a spurious extra strobe.

// File: rtl/wait_div_pkg.sv
package wait_div_pkg;
  typedef enum logic [1:0] {
    KIND_IDLE  = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_OTHER = 2'd3
  } bus_kind_e;

  typedef struct packed {
    logic [1:0] int_sel;
    logic [1:0] ext_sel;
    logic       timer_en;
    logic       ram_dis;
    logic       ram_wr;
  } wait_ctrl_t;

  localparam int LEN_W     = 5;
  localparam int MAX_LEN   = 20;

  // core-side length; settings 2 and 3 do not divide the base rate evenly
  function automatic logic [LEN_W-1:0] cpu_len(input logic [1:0] sel);
    case (sel)
      2'd0:    cpu_len = 5'd2;
      2'd1:    cpu_len = 5'd4;
      2'd2:    cpu_len = 5'd10;
      default: cpu_len = 5'd20;
    endcase
  endfunction

  // timer-side advance stays a clean power of two
  function automatic logic [LEN_W-1:0] timer_len(input logic [1:0] sel);
    case (sel)
      2'd0:    timer_len = 5'd2;
      2'd1:    timer_len = 5'd4;
      2'd2:    timer_len = 5'd8;
      default: timer_len = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/wait_ctrl_reg.sv
module wait_ctrl_reg
  import wait_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output wait_ctrl_t ctrl_o
);
  wait_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{int_sel: 2'd0, ext_sel: 2'd0, timer_en: 1'b1, ram_dis: 1'b0, ram_wr: 1'b1};
    end else if (we_i) begin
      ctrl_q.int_sel  <= wdata_i[7:6];
      ctrl_q.ext_sel  <= wdata_i[5:4];
      ctrl_q.timer_en <= wdata_i[3];
      ctrl_q.ram_dis  <= wdata_i[2];
      ctrl_q.ram_wr   <= wdata_i[1];
    end
  end

  assign ctrl_o = ctrl_q;

  a_r9_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q));
endmodule

// File: rtl/wait_class_decode.sv
module wait_class_decode
  import wait_div_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IO_BASE   = 16'h00F0,
  parameter logic [ADDR_W-1:0] IO_MASK   = 16'hFFF0,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hFFC0
) (
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              boot_en_i,
  input  wait_ctrl_t        ctrl_i,
  output logic              use_int_o,
  output logic [1:0]        sel_o
);
  logic is_idle, in_io, in_boot;

  always_comb begin
    is_idle   = (bus_kind_e'(kind_i) == KIND_IDLE);
    in_io     = ((addr_i & IO_MASK) == IO_BASE);
    in_boot   = boot_en_i && (addr_i >= BOOT_BASE);
    use_int_o = is_idle || in_io || in_boot;
    sel_o     = use_int_o ? ctrl_i.int_sel : ctrl_i.ext_sel;
  end
endmodule

// File: rtl/base_prescaler.sv
module base_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [PW-1:0] phase_q;

  assign tick_o = (phase_q == PW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (tick_o)    phase_q <= '0;
    else                phase_q <= phase_q + 1'b1;
  end

  a_r2_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(phase_q) < DIV);
endmodule

// File: rtl/cycle_counter.sv
module cycle_counter
  import wait_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] ticks_i,
  input  logic             base_tick_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [LEN_W-1:0] ticks_o
);
  logic [LEN_W-1:0] cnt_q, hold_q, ticks_q;
  logic             busy_q, done_q, last;

  assign accept_o = req_i && !busy_q;
  assign last     = busy_q && base_tick_i && (cnt_q == 5'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      hold_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ticks_q <= '0;
    end else begin
      done_q  <= last;
      ticks_q <= last ? hold_q : '0;
      if (accept_o) begin
        cnt_q  <= len_i;
        hold_q <= ticks_i;
        busy_q <= 1'b1;
      end else if (last) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else if (busy_q && base_tick_i) begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign ticks_o = ticks_q;

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r6_free_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  a_r6_fall_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  a_r7_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && req_i) |=> cnt_q <= $past(cnt_q));
  a_r4_ticks_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> ticks_q == '0);
  a_r3_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= MAX_LEN);
  a_r3_nonzero_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> len_i >= 5'd2);
endmodule

// File: rtl/bus_wait_divider.sv
module bus_wait_divider
  import wait_div_pkg::*;
#(
  parameter int                BASE_DIV  = 12,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IO_BASE   = 16'h00F0,
  parameter logic [ADDR_W-1:0] IO_MASK   = 16'hFFF0,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hFFC0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              boot_rom_en_i,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [4:0]        timer_ticks_o,
  output logic              timer_en_o,
  output logic              ram_writable_o,
  output logic              ram_disable_o
);
  wait_ctrl_t       ctrl;
  logic             use_int, base_tick, accept;
  logic [1:0]       sel;
  logic [LEN_W-1:0] len, ticks;

  wait_ctrl_reg u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl_we_i),
    .wdata_i(ctrl_wdata_i),
    .ctrl_o (ctrl)
  );

  wait_class_decode #(
    .ADDR_W   (ADDR_W),
    .IO_BASE  (IO_BASE),
    .IO_MASK  (IO_MASK),
    .BOOT_BASE(BOOT_BASE)
  ) u_dec (
    .kind_i   (req_kind_i),
    .addr_i   (addr_i),
    .boot_en_i(boot_rom_en_i),
    .ctrl_i   (ctrl),
    .use_int_o(use_int),
    .sel_o    (sel)
  );

  assign len   = cpu_len(sel);
  assign ticks = timer_len(sel);

  base_prescaler #(.DIV(BASE_DIV)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(accept),
    .tick_o   (base_tick)
  );

  cycle_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_valid_i),
    .len_i      (len),
    .ticks_i    (ticks),
    .base_tick_i(base_tick),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ticks_o    (timer_ticks_o)
  );

  assign timer_en_o     = ctrl.timer_en;
  assign ram_writable_o = ctrl.ram_wr;
  assign ram_disable_o  = ctrl.ram_dis;

  a_r5_idle_internal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_kind_i == 2'd0) |-> use_int);
  a_r2_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: tb/bus_wait_divider_test.sv
module bus_wait_divider_test;
  localparam int DIV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] addr = 16'h0;
  logic        boot_en = 1'b1;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = 8'h0;
  logic        busy, done, timer_en, ram_wr, ram_dis;
  logic [4:0]  ticks;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [1:0] m_int = 2'd0, m_ext = 2'd0;

  bus_wait_divider uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .addr_i(addr), .boot_rom_en_i(boot_en), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .busy_o(busy), .done_o(done), .timer_ticks_o(ticks), .timer_en_o(timer_en),
    .ram_writable_o(ram_wr), .ram_disable_o(ram_dis)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles exp below 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] s);
    case (s) 2'd0: return 2; 2'd1: return 4; 2'd2: return 10; default: return 20; endcase
  endfunction
  function automatic int tick_of(input logic [1:0] s);
    return 2 << s;
  endfunction
  function automatic logic [1:0] sel_of(input logic [1:0] k, input logic [15:0] a, input logic b);
    if (k == 2'd0 || (a & 16'hFFF0) == 16'h00F0 || (b && a >= 16'hFFC0)) return m_int;
    return m_ext;
  endfunction

  task automatic wr_ctrl(input logic [7:0] d);
    ctrl_we = 1'b1; ctrl_wdata = d;
    @(posedge clk); @(negedge clk);
    ctrl_we = 1'b0;
    m_int = d[7:6]; m_ext = d[5:4];
  endtask

  // start at a negedge; optional ctrl write and extra request mid-cycle
  task automatic run(input string tag, input logic [1:0] k, input logic [15:0] a, input logic b,
                     input int wr_at, input logic [7:0] wr_d, input int rq_at);
    logic [1:0] s;
    int n;
    int el, et;
    s = sel_of(k, a, b);
    el = len_of(s) * DIV; et = tick_of(s);
    req_valid = 1'b1; req_kind = k; addr = a; boot_en = b;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R2 busy after accept"}, busy, 1);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      ctrl_we = 1'b0; req_valid = 1'b0;
      if (done) break;
      if (n == wr_at) begin ctrl_we = 1'b1; ctrl_wdata = wr_d; end
      if (n == rq_at) begin req_valid = 1'b1; req_kind = 2'd1; addr = 16'h1234; end
    end
    if (wr_at > 0) begin m_int = wr_d[7:6]; m_ext = wr_d[5:4]; end
    check({tag, " R2 R3 length"}, n, el);
    check({tag, " R4 ticks"}, ticks, et);
    check({tag, " R6 busy low on done"}, busy, 0);
    @(posedge clk); @(negedge clk);
    check({tag, " R6 done one clock"}, done, 0);
    check({tag, " R4 ticks cleared"}, ticks, 0);
    check({tag, " R7 nothing queued"}, busy, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 ticks", ticks, 0);
    check("R1 timer_en", timer_en, 1);
    check("R1 ram_wr", ram_wr, 1);
    check("R1 ram_dis", ram_dis, 0);
    run("R1 default length", 2'd1, 16'h4000, 1'b1, 0, 8'h0, 0);

    // R9 flag bits, bit 0 ignored
    wr_ctrl(8'b0000_0101);
    check("R9 timer_en", timer_en, 0);
    check("R9 ram_dis", ram_dis, 1);
    check("R9 ram_wr", ram_wr, 0);
    wr_ctrl(8'b0000_1010);
    check("R9 timer_en set", timer_en, 1);
    check("R9 ram_dis clr", ram_dis, 0);
    check("R9 ram_wr set", ram_wr, 1);

    // R3 R4 every setting on each side; R5 boundaries
    for (int s = 0; s < 4; s++) begin
      wr_ctrl({2'(s), 2'(3 - s), 4'b1010});
      run("R3 ext", 2'd1, 16'h2000, 1'b1, 0, 8'h0, 0);
      run("R3 int io", 2'd2, 16'h00F0, 1'b1, 0, 8'h0, 0);
    end
    wr_ctrl(8'b1100_1010); // int=3, ext=0
    run("R5 idle", 2'd0, 16'h2000, 1'b0, 0, 8'h0, 0);
    run("R5 0x00EF", 2'd1, 16'h00EF, 1'b1, 0, 8'h0, 0);
    run("R5 0x00FF", 2'd1, 16'h00FF, 1'b1, 0, 8'h0, 0);
    run("R5 0x0100", 2'd2, 16'h0100, 1'b1, 0, 8'h0, 0);
    run("R5 0xFFBF", 2'd1, 16'hFFBF, 1'b1, 0, 8'h0, 0);
    run("R5 0xFFC0 boot", 2'd1, 16'hFFC0, 1'b1, 0, 8'h0, 0);
    run("R5 0xFFC0 noboot", 2'd1, 16'hFFC0, 1'b0, 0, 8'h0, 0);
    run("R5 0xFFFF kind3", 2'd3, 16'hFFFF, 1'b1, 0, 8'h0, 0);

    // R7 R8 mid-cycle interference
    wr_ctrl(8'b0001_1010); // ext=1
    run("R8 write mid-cycle", 2'd1, 16'h3000, 1'b1, 3, 8'b0010_1010, 0);
    run("R8 new value used", 2'd1, 16'h3000, 1'b1, 0, 8'h0, 0);
    run("R7 request while busy", 2'd1, 16'h00F4, 1'b1, 0, 8'h0, 5);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [1:0]  k;
      logic [15:0] a;
      logic        b;
      k = 2'($urandom % 4);
      b = 1'($urandom % 2);
      case ($urandom % 5)
        0: a = 16'h00F0 | 16'($urandom % 16);
        1: a = 16'hFFC0 + 16'($urandom % 64);
        2: a = ($urandom % 2) ? 16'h00EF : 16'h0100;
        default: a = 16'($urandom);
      endcase
      if ($urandom % 4 == 0) wr_ctrl(8'($urandom) | 8'h0A);
      run("R5 random", k, a, b, 0, 8'h0, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule